// File: doc/BRIEF.md
# Two-Channel Down-Counter Block

This block holds two down-counting timer channels behind one word-addressed register port. A 4 KB window, seen as 1024 words, is split into fixed regions. The lowest eight words belong to channel 0. The next eight words belong to channel 1, which uses the same local layout starting from local word 0. The top eight words are a read-only identification table. All other words read as zero. This includes the two test-control words at word 0x3C0 and word 0x3C1.

Each channel has its own tick-enable input. Both channels run from the same system clock, but each can count at its own rate. Each channel raises a raw expiry flag, masks it with its own interrupt enable, and the two masked flags are merged by OR onto a single interrupt line.

A channel has eight local words:

| Local word | Access | Content |
| --- | --- | --- |
| 0 | read/write | Reload value. A write also loads the counter. |
| 1 | read-only | Current count. |
| 2 | read/write | Configuration. Bit 0 run, bit 1 interrupt enable, bit 2 single-shot, bit 3 reload-on-expiry. |
| 3 | write-only | Acknowledge. Any write clears the raw flag. |
| 4 | read-only | Raw flag. |
| 5 | read-only | Masked flag. |
| 6 | read/write | Reload value only. The counter is not touched. |

Top module: `dual_timer_wrap`

## Requirements
- R1: After reset, both channels read configuration 0x2 (interrupt enable only), count 0 and reload 0. The interrupt output and read data are 0.
- R2: Words 0–7 address channel 0 and words 8–15 address channel 1. For channel 1 the local word is the address minus 8.
- R3: Words 0x3F8 to 0x3FF return, in address order, the bytes 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, zero-extended to 32 bits.
- R4: Reads of the test words 0x3C0 and 0x3C1, and of every other unmapped word, return zero.
- R5: Writes outside words 0–15 change nothing, including writes to the identification words.
- R6: The interrupt output is the OR of the two channels' masked flags.
- R7: A running channel counts only on cycles where its own tick input is high. The other channel's tick has no effect on it.
- R8: Read data appears on the cycle after the read strobe and is 0 on any cycle that does not follow a strobe.
- R9: A write to local word 0 loads both the reload value and the counter. A running channel decrements by one on each tick. A tick that finds the count at 0 sets the raw flag. With bit 3 set (and bit 2 clear), that tick also reloads the counter.
- R10: A write to local word 3 clears the raw flag. If an expiry happens in the same cycle, the flag stays set.
- R11: Local word 5 and the channel's share of the interrupt equal the raw flag ANDed with configuration bit 1.
- R12: In single-shot mode (bit 2 set), expiry clears the run bit and the count stays at 0. With bits 2 and 3 both clear, expiry wraps the count to all ones.
- R13: A write to local word 6 changes the reload value but not the current count.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 10 | Word address within the 4 KB window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| tick0 | input | 1 | Count enable for channel 0 |
| tick1 | input | 1 | Count enable for channel 1 |
| irq | output | 1 | Merged interrupt |

## Verification
Two events can land on a channel in the same cycle: a tick that expires the counter and a software write to the acknowledge word. The bench first counts a channel down to zero. It then asserts that channel's tick together with the acknowledge write. It judges the outcome by reading the raw flag afterwards and sampling the merged interrupt: both must remain set, because expiry wins. A following acknowledge with no tick must clear them.

// File: rtl/dtw_pkg.sv
package dtw_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 10;
    localparam int LOCAL_W  = 3;
    localparam int N_CHAN   = 2;

    typedef enum logic [1:0] {
        RG_CH0  = 2'd0,
        RG_CH1  = 2'd1,
        RG_ID   = 2'd2,
        RG_NONE = 2'd3
    } region_e;

    typedef enum logic [LOCAL_W-1:0] {
        LW_RELOAD = 3'd0,
        LW_COUNT  = 3'd1,
        LW_CFG    = 3'd2,
        LW_ACK    = 3'd3,
        LW_RAW    = 3'd4,
        LW_MASKED = 3'd5,
        LW_SHADOW = 3'd6,
        LW_SPARE  = 3'd7
    } local_word_e;

    typedef struct packed {
        logic reload_on_exp;
        logic single_shot;
        logic irq_en;
        logic run;
    } chan_cfg_t;

    localparam chan_cfg_t CFG_RESET = '{reload_on_exp: 1'b0, single_shot: 1'b0,
                                        irq_en: 1'b1, run: 1'b0};

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h04;
            3'd1:    return 8'h18;
            3'd2:    return 8'h14;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/dtw_decode.sv
module dtw_decode
    import dtw_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0]      addr,
    output region_e            region,
    output logic [LOCAL_W-1:0] local_ofs
);
    localparam logic [AW-1:0] ID_BASE  = AW'((1 << AW) - 8);
    localparam logic [AW-1:0] CH1_BASE = AW'(8);
    localparam logic [AW-1:0] CH_END   = AW'(16);

    always_comb begin
        local_ofs = addr[LOCAL_W-1:0];
        if (addr < CH1_BASE)
            region = RG_CH0;
        else if (addr < CH_END)
            region = RG_CH1;
        else if (addr >= ID_BASE)
            region = RG_ID;
        else
            region = RG_NONE;
    end
endmodule

// File: rtl/dtw_chan.sv
module dtw_chan
    import dtw_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DW    = DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               wr_en,
    input  logic [LOCAL_W-1:0] ofs,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rvalue,
    output logic               irq
);
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] count_q;
    chan_cfg_t        cfg_q;
    logic             raw_q;
    logic             expire;

    assign expire = tick && cfg_q.run && (count_q == '0);
    assign irq    = raw_q && cfg_q.irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            count_q  <= '0;
            cfg_q    <= CFG_RESET;
            raw_q    <= 1'b0;
        end else begin
            if (tick && cfg_q.run) begin
                if (count_q == '0) begin
                    raw_q <= 1'b1;
                    if (cfg_q.single_shot)
                        cfg_q.run <= 1'b0;
                    else if (cfg_q.reload_on_exp)
                        count_q <= reload_q;
                    else
                        count_q <= '1;
                end else begin
                    count_q <= count_q - 1'b1;
                end
            end
            if (wr_en) begin
                case (local_word_e'(ofs))
                    LW_RELOAD: begin
                        reload_q <= wdata[CNT_W-1:0];
                        count_q  <= wdata[CNT_W-1:0];
                    end
                    LW_CFG:    cfg_q    <= chan_cfg_t'(wdata[3:0]);
                    LW_ACK:    if (!expire) raw_q <= 1'b0;
                    LW_SHADOW: reload_q <= wdata[CNT_W-1:0];
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        case (local_word_e'(ofs))
            LW_RELOAD, LW_SHADOW: rvalue = DW'(reload_q);
            LW_COUNT:             rvalue = DW'(count_q);
            LW_CFG:               rvalue = DW'(cfg_q);
            LW_RAW:               rvalue = DW'(raw_q);
            LW_MASKED:            rvalue = DW'(irq);
            default:              rvalue = '0;
        endcase
    end
endmodule

// File: rtl/dual_timer_wrap.sv
module dual_timer_wrap
    import dtw_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tick0,
    input  logic              tick1,
    output logic              irq
);
    region_e            region;
    logic [LOCAL_W-1:0] local_ofs;
    logic [N_CHAN-1:0]  chan_tick;
    logic [N_CHAN-1:0]  chan_irq;
    logic [DATA_W-1:0]  chan_rd [N_CHAN];
    logic [DATA_W-1:0]  rd_mux;

    assign chan_tick = {tick1, tick0};

    dtw_decode #(.AW(ADDR_W)) u_decode (
        .addr      (addr),
        .region    (region),
        .local_ofs (local_ofs)
    );

    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        logic chan_wr;
        assign chan_wr = wr_en && (region == region_e'(g));
        dtw_chan #(.CNT_W(CNT_W), .DW(DATA_W)) u_chan (
            .clk    (clk),
            .rst    (rst),
            .tick   (chan_tick[g]),
            .wr_en  (chan_wr),
            .ofs    (local_ofs),
            .wdata  (wdata),
            .rvalue (chan_rd[g]),
            .irq    (chan_irq[g])
        );
    end

    always_comb begin
        case (region)
            RG_CH0:  rd_mux = chan_rd[0];
            RG_CH1:  rd_mux = chan_rd[1];
            RG_ID:   rd_mux = DATA_W'(id_byte(local_ofs));
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else
            rdata <= rd_en ? rd_mux : '0;
    end

    assign irq = |chan_irq;
endmodule

// File: rtl/dtw_checker.sv
module dtw_checker
    import dtw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              tick0,
    input logic              tick1,
    input logic              irq
);
    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_en) |-> rdata == '0); // R8

    AST_TEST_WORDS_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(rd_en) && ($past(addr) == 10'h3C0 || $past(addr) == 10'h3C1) |-> rdata == '0); // R4

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(rd_en) && $past(addr) >= 10'd16 && $past(addr) < 10'h3F8 |-> rdata == '0); // R4

    AST_ID_FIRST: assert property (@(posedge clk) disable iff (rst)
        $past(rd_en) && $past(addr) == 10'h3F8 |-> rdata == 32'h04); // R3

    AST_ID_LAST: assert property (@(posedge clk) disable iff (rst)
        $past(rd_en) && $past(addr) == 10'h3FF |-> rdata == 32'hB1); // R3

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(tick0) || $past(tick1) || $past(wr_en)); // R6
endmodule

bind dual_timer_wrap dtw_checker u_dtw_checker (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .rdata (rdata),
    .tick0 (tick0),
    .tick1 (tick1),
    .irq   (irq)
);

// File: tb/dual_timer_wrap_bench.sv
module dual_timer_wrap_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tick0 = 1'b0;
    logic        tick1 = 1'b0;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [9:0]  a;
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    rd_item_t  sb_q[$];
    logic      rd_seen = 1'b0;

    always #2 clk = ~clk;

    dual_timer_wrap u_dual_timer_wrap (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick0(tick0), .tick1(tick1), .irq(irq)
    );

    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen && sb_q.size() > 0) begin
            rd_item_t it;
            it = sb_q.pop_front();
            checks++;
            if (rdata !== it.exp) begin
                fails++;
                $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, rdata, it.exp);
            end
        end
    end

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        sb_q.push_back('{a: a, exp: e, tag: tag});
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input logic t0, input logic t1, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick0 = t0; tick1 = t1;
            @(negedge clk);
            tick0 = 1'b0; tick1 = 1'b0;
        end
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        checks++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, e);
        end
    endtask

    task automatic summary;
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        logic [7:0] ids [8] = '{8'h04, 8'h18, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk_irq(1'b0, "R1");
        rd(10'd2,  32'h2, "R1 ch0 cfg");
        rd(10'd10, 32'h2, "R1 ch1 cfg");
        rd(10'd1,  32'h0, "R1 ch0 count");
        rd(10'd8,  32'h0, "R1 ch1 reload");
        // R3 / R8 id table, zero-extended
        for (int i = 0; i < 8; i++)
            rd(10'h3F8 + 10'(i), {24'h0, ids[i]}, "R3 R8 id");
        // R4 unmapped
        rd(10'h3C0, 32'h0, "R4 test ctrl");
        rd(10'h3C1, 32'h0, "R4 test out");
        rd(10'd16,  32'h0, "R4 gap");
        rd(10'h200, 32'h0, "R4 gap");
        // R2 / R9 rebased channel access
        wr(10'd0, 32'd5);
        wr(10'd8, 32'd3);
        rd(10'd0, 32'd5, "R2 ch0 reload");
        rd(10'd1, 32'd5, "R9 ch0 count loaded");
        rd(10'd9, 32'd3, "R2 ch1 count");
        // R5 ignored writes
        wr(10'h3F8, 32'hFF);
        wr(10'h100, 32'h55);
        wr(10'h3C0, 32'h1);
        wr(10'd16,  32'h7);
        rd(10'h3F8, 32'h04, "R5 id intact");
        rd(10'd0,  32'd5, "R5 ch0 intact");
        rd(10'd8,  32'd3, "R5 ch1 intact");
        rd(10'd10, 32'h2, "R5 ch1 cfg intact");
        // R7 independent ticks
        wr(10'd2,  32'hB);
        wr(10'd10, 32'hB);
        ticks(1'b1, 1'b0, 2);
        rd(10'd1, 32'd3, "R7 ch0 counted");
        rd(10'd9, 32'd3, "R7 ch1 held");
        ticks(1'b0, 1'b1, 1);
        rd(10'd9, 32'd2, "R7 ch1 counted");
        rd(10'd1, 32'd3, "R7 ch0 held");
        // R9 periodic expiry
        ticks(1'b1, 1'b0, 3);
        rd(10'd1, 32'd0, "R9 at zero");
        rd(10'd4, 32'd0, "R9 no flag yet");
        ticks(1'b1, 1'b0, 1);
        rd(10'd4, 32'd1, "R9 raw set");
        rd(10'd1, 32'd5, "R9 reloaded");
        rd(10'd5, 32'd1, "R11 masked");
        chk_irq(1'b1, "R6 ch0");
        // R11 mask off
        wr(10'd2, 32'h9);
        chk_irq(1'b0, "R11 masked off");
        rd(10'd5, 32'd0, "R11 masked word");
        rd(10'd4, 32'd1, "R11 raw kept");
        // R10 ack
        wr(10'd3, 32'h0);
        rd(10'd4, 32'd0, "R10 ack clears");
        wr(10'd2, 32'hB);
        chk_irq(1'b0, "R10 after ack");
        // R6 from ch1
        ticks(1'b0, 1'b1, 3);
        chk_irq(1'b1, "R6 ch1");
        rd(10'd12, 32'd1, "R6 ch1 raw");
        rd(10'd9, 32'd3, "R9 ch1 reloaded");
        wr(10'd11, 32'h0);
        chk_irq(1'b0, "R6 ch1 ack");
        // R10 same-cycle expiry and ack
        ticks(1'b1, 1'b0, 5);
        rd(10'd1, 32'd0, "R10 ch0 zero");
        @(negedge clk);
        tick0 = 1'b1; wr_en = 1'b1; addr = 10'd3; wdata = '0;
        @(negedge clk);
        tick0 = 1'b0; wr_en = 1'b0;
        chk_irq(1'b1, "R10 expiry wins");
        rd(10'd4, 32'd1, "R10 raw kept");
        wr(10'd3, 32'h0);
        chk_irq(1'b0, "R10 later ack");
        // R12 single shot
        wr(10'd0, 32'd1);
        wr(10'd2, 32'h7);
        ticks(1'b1, 1'b0, 2);
        rd(10'd2, 32'h6, "R12 run cleared");
        rd(10'd1, 32'd0, "R12 count held");
        chk_irq(1'b1, "R12 irq");
        ticks(1'b1, 1'b0, 1);
        rd(10'd1, 32'd0, "R12 stopped");
        wr(10'd3, 32'h0);
        // R12 free running wrap
        wr(10'd8, 32'd0);
        wr(10'd10, 32'h3);
        ticks(1'b0, 1'b1, 1);
        rd(10'd9, 32'hFFFF_FFFF, "R12 wrap");
        rd(10'd12, 32'd1, "R12 free raw");
        // R13 shadow reload
        wr(10'd14, 32'd9);
        rd(10'd9, 32'hFFFF_FFFF, "R13 count kept");
        rd(10'd8, 32'd9, "R13 reload set");
        rd(10'd14, 32'd9, "R13 shadow read");
        summary();
    end
endmodule